// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external host read and write a byte-wide register file over a four-wire serial link in clock mode 0. Each transaction opens with a command byte. Its top bit gives the direction (1 = read, 0 = write) and the remaining seven bits give the starting register address. Data bytes follow the command byte. Each data byte moves the register address on by one, so a host can stream a whole block of registers in one selection.

The serial pins are oversampled in the system clock domain. The block then presents a plain single-cycle register port: an address, a write strobe with write data, and a read strobe with combinational read data. A fast-access input narrows the link to a read-only window of sensor registers. The synchronized chip-select level is also exported, so that neighbouring logic can route the shared pins to a two-wire controller while the link is deselected.

Top module: `spi_regport`

## Requirements
- R1: Bits are received most significant first on rising serial-clock edges. In the command byte, bit 7 = 1 means read, bit 7 = 0 means write, and bits 6..0 are the start address.
- R2: A 16-clock write transaction makes exactly one `reg_wr` pulse, carrying the command address and the data byte. `reg_rd` and `reg_wr` never assert together.
- R3: In a write burst, each further data byte goes to the next address. The address wraps from 127 to 0.
- R4: In a read, the addressed register is returned on `spi_sdo` most significant bit first. The output changes after falling serial-clock edges, so each bit is stable when the host samples it at the rising edge.
- R5: In a read burst, each further data byte returns the register at the next address, with the same wrap from 127 to 0.
- R6: `spi_sdo_en` is low whenever the synchronized chip select is high, and high while it is low.
- R7: While `fast_mode` is 1, write transactions produce no `reg_wr` pulse, and the register file is unchanged.
- R8: While `fast_mode` is 1, a read of an address outside SENS_LO..SENS_HI (default 0x20..0x2F) returns 0x00 and makes no `reg_rd` pulse. Addresses inside the window read normally.
- R9: Chip select rising part-way through a byte discards that byte and performs no write. The next selection starts again with a command byte.
- R10: `i2c_sel` follows the synchronized chip-select level: 1 when deselected (two-wire mode), 0 when selected.
- R11: After reset, `reg_wr`, `reg_rd` and `spi_sdo_en` are 0 and `i2c_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data from the host |
| fast_mode | input | 1 | Restricts access to sensor reads only |
| spi_sdo | output | 1 | Serial data to the host |
| spi_sdo_en | output | 1 | Output enable for the pad driver of `spi_sdo` |
| i2c_sel | output | 1 | High when the shared pins belong to the two-wire path |
| reg_addr | output | 7 | Register address |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data for `reg_addr`, valid in the same cycle |

## Verification
The bench writes and then reads back every one of the 128 addresses. An off-by-one in the bit counter would shift every byte by one bit. A misplaced direction bit would turn reads into writes. Bursts that cross address 127 expose an address that does not wrap, or one that advances before the first data byte and so corrupts the first data byte of each burst. Fast-mode reads that straddle both window edges catch a window compare off by one. A transaction aborted mid-byte catches a design that commits the partial byte or keeps stale bit-count state into the next selection.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

   // transaction phase: command byte first, then data bytes
   typedef enum logic [0:0] {
      PH_CMD  = 1'b0,
      PH_DATA = 1'b1
   } phase_t;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_regport_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], din};
   end

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/spi_regport_shifter.sv
module spi_regport_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              cs_s,
   input  logic              sdi_s,
   input  logic [DATA_W-1:0] tx_next,
   output logic              byte_done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              sdo_bit
);

   localparam int                CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

   logic              sclk_q;
   logic              rise, fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-2:0] rx_sh;
   logic [DATA_W-1:0] tx_sh;

   assign rise = sclk_s & ~sclk_q;
   assign fall = ~sclk_s & sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
      end else begin
         sclk_q <= sclk_s;
         if (cs_s) begin
            bit_cnt <= '0;
            tx_sh   <= '0;
         end else begin
            if (rise) begin
               rx_sh   <= {rx_sh[DATA_W-3:0], sdi_s};
               bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
            end
            if (fall) begin
               // byte boundary: present the prepared byte, else shift
               if (bit_cnt == '0) tx_sh <= tx_next;
               else               tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign byte_done = ~cs_s & rise & (bit_cnt == LAST);
   assign rx_byte   = {rx_sh, sdi_s};
   assign sdo_bit   = tx_sh[DATA_W-1];

   // deselect clears any partial byte
   p_abort_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> (bit_cnt == '0));

   // a completed byte is reported for exactly one cycle
   p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !byte_done);

endmodule

// File: rtl/spi_regport_ctrl.sv
module spi_regport_ctrl
   import spi_regport_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SENS_LO = 32,
   parameter int SENS_HI = 47
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              byte_done,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              fast_mode,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic [DATA_W-2:0] reg_addr,
   output logic              reg_wr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_rd,
   output logic [DATA_W-1:0] tx_next
);

   localparam int ADDR_W = DATA_W - 1;
   localparam int ADDR_MAX = (1 << ADDR_W) - 1;

   phase_t            phase;
   logic              is_read;
   logic              rd_pend, rd_ok;
   logic              wr_pend, wr_go;
   logic [ADDR_W-1:0] addr_q, nxt_addr;
   logic [DATA_W-1:0] wdata_q, tx_q;
   logic              lo_ok, hi_ok, win_ok;

   assign nxt_addr = (phase == PH_CMD) ? rx_byte[ADDR_W-1:0] : addr_q + 1'b1;

   // window bounds that cover the full range need no comparator
   generate
      if (SENS_LO == 0) begin : g_lo_open
         assign lo_ok = 1'b1;
      end else begin : g_lo_cmp
         assign lo_ok = (nxt_addr >= ADDR_W'(SENS_LO));
      end
      if (SENS_HI >= ADDR_MAX) begin : g_hi_open
         assign hi_ok = 1'b1;
      end else begin : g_hi_cmp
         assign hi_ok = (nxt_addr <= ADDR_W'(SENS_HI));
      end
   endgenerate

   assign win_ok = lo_ok & hi_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_CMD;
         is_read <= 1'b0;
         rd_pend <= 1'b0;
         rd_ok   <= 1'b0;
         wr_pend <= 1'b0;
         wr_go   <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         tx_q    <= '0;
      end else begin
         rd_pend <= 1'b0;
         wr_pend <= 1'b0;
         if (rd_pend) tx_q <= rd_ok ? reg_rdata : '0;
         if (wr_pend) addr_q <= addr_q + 1'b1;
         if (cs_s) begin
            phase <= PH_CMD;
         end else if (byte_done) begin
            if (phase == PH_CMD) begin
               phase   <= PH_DATA;
               is_read <= rx_byte[DATA_W-1];
               addr_q  <= nxt_addr;
               tx_q    <= '0;
               if (rx_byte[DATA_W-1]) begin
                  rd_pend <= 1'b1;
                  rd_ok   <= ~fast_mode | win_ok;
               end
            end else if (is_read) begin
               addr_q  <= nxt_addr;
               rd_pend <= 1'b1;
               rd_ok   <= ~fast_mode | win_ok;
            end else begin
               wr_pend <= 1'b1;
               wr_go   <= ~fast_mode;
               wdata_q <= rx_byte;
            end
         end
      end
   end

   assign reg_rd    = rd_pend & rd_ok;
   assign reg_wr    = wr_pend & wr_go;
   assign reg_addr  = addr_q;
   assign reg_wdata = wdata_q;
   assign tx_next   = tx_q;

   p_no_wr_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> !$past(fast_mode));

   p_rd_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && $past(fast_mode)) |->
         (int'(reg_addr) >= SENS_LO && int'(reg_addr) <= SENS_HI));

   p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd && reg_wr));

   p_wr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> (reg_addr == $past(reg_addr) + 1'b1));

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SENS_LO     = 32,
   parameter int SENS_HI     = 47
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_sdi,
   input  logic              fast_mode,
   output logic              spi_sdo,
   output logic              spi_sdo_en,
   output logic              i2c_sel,
   output logic [DATA_W-2:0] reg_addr,
   output logic              reg_wr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_rd,
   input  logic [DATA_W-1:0] reg_rdata
);

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("spi_regport: DATA_W must be at least 4");
      end
      if (SENS_LO > SENS_HI || SENS_HI >= (1 << (DATA_W - 1))) begin : g_bad_window
         $error("spi_regport: sensor window out of range");
      end
   endgenerate

   logic              sclk_s, cs_s, sdi_s;
   logic              byte_done, sdo_bit;
   logic [DATA_W-1:0] rx_byte, tx_next;

   spi_regport_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({spi_sclk, spi_cs_n, spi_sdi}),
      .dout  ({sclk_s, cs_s, sdi_s})
   );

   spi_regport_shifter #(
      .DATA_W (DATA_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (sclk_s),
      .cs_s      (cs_s),
      .sdi_s     (sdi_s),
      .tx_next   (tx_next),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .sdo_bit   (sdo_bit)
   );

   spi_regport_ctrl #(
      .DATA_W  (DATA_W),
      .SENS_LO (SENS_LO),
      .SENS_HI (SENS_HI)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_s      (cs_s),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .fast_mode (fast_mode),
      .reg_rdata (reg_rdata),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rd    (reg_rd),
      .tx_next   (tx_next)
   );

   assign i2c_sel    = cs_s;
   assign spi_sdo_en = ~cs_s;
   assign spi_sdo    = sdo_bit & ~cs_s;

   // strobes only follow a completed byte, never while deselected long
   p_no_strobe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cs_s) && cs_s && $past(cs_s, 2)) |-> !(reg_wr || reg_rd) || $past(byte_done) == 1'b0);

endmodule

// File: tb/spi_regport_bench.sv
module spi_regport_bench;

   localparam int HALF = 8;
   localparam int LO   = 32;
   localparam int HI   = 47;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_sdi = 1'b0, fast_mode = 1'b0;
   logic       spi_sdo, spi_sdo_en, i2c_sel, reg_wr, reg_rd;
   logic [6:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;

   logic [7:0] mem    [128];
   logic [7:0] shadow [128];
   logic [7:0] tx_b   [16];
   logic [7:0] rx_b   [16];

   int checks = 0, fails = 0, wr_cnt = 0, rd_cnt = 0, rd_bad = 0, cyc = 0;

   always #10 clk = ~clk;

   spi_regport u_spi_regport (
      .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
      .spi_sdi(spi_sdi), .fast_mode(fast_mode), .spi_sdo(spi_sdo),
      .spi_sdo_en(spi_sdo_en), .i2c_sel(i2c_sel), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
      .reg_rdata(reg_rdata)
   );

   // register file model
   assign reg_rdata = mem[reg_addr];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 128; i++) mem[i] <= 8'(i * 37 + 5);
      end else if (reg_wr) begin
         mem[reg_addr] <= reg_wdata;
      end
   end

   always @(posedge clk) begin
      if (rst_n && reg_wr) wr_cnt <= wr_cnt + 1;
      if (rst_n && reg_rd) rd_cnt <= rd_cnt + 1;
      if (rst_n && reg_rd && fast_mode && (int'(reg_addr) < LO || int'(reg_addr) > HI))
         rd_bad <= rd_bad + 1;
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 190000) begin
         fails = fails + 1;
         $display("FAIL watchdog (all R): act=%0d exp=<190000 cycles", cyc);
         summary();
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   task automatic xfer(input int n);
      spi_cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int b = 0; b < n; b++) begin
         for (int i = 7; i >= 0; i--) begin
            spi_sdi = tx_b[b][i];
            repeat (HALF) @(negedge clk);
            rx_b[b][i] = spi_sdo;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
         end
      end
      repeat (HALF) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic partial(input logic [15:0] pat, input int nbits);
      spi_cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 15; i > 15 - nbits; i--) begin
         spi_sdi = pat[i];
         repeat (HALF) @(negedge clk);
         spi_sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         spi_sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   initial begin
      int w0, bad;
      logic [6:0] a;
      repeat (4) @(negedge clk);
      // R11 reset state while reset is held and just after release
      check(reg_wr == 1'b0 && reg_rd == 1'b0, "R11 strobes idle", {reg_wr, reg_rd}, 0);
      check(spi_sdo_en == 1'b0, "R11 sdo_en", spi_sdo_en, 0);
      check(i2c_sel == 1'b1, "R11 i2c_sel", i2c_sel, 1);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 128; i++) shadow[i] = 8'(i * 37 + 5);

      // R6 / R10 selection levels
      spi_cs_n = 1'b0;
      repeat (6) @(negedge clk);
      check(spi_sdo_en == 1'b1, "R6 selected", spi_sdo_en, 1);
      check(i2c_sel == 1'b0, "R10 selected", i2c_sel, 0);
      spi_cs_n = 1'b1;
      repeat (6) @(negedge clk);
      check(spi_sdo_en == 1'b0, "R6 deselected", spi_sdo_en, 0);
      check(i2c_sel == 1'b1, "R10 deselected", i2c_sel, 1);

      // R1 R2 single write to every address
      bad = 0;
      for (int i = 0; i < 128; i++) begin
         w0 = wr_cnt;
         tx_b[0] = 8'(i);
         tx_b[1] = 8'(i) ^ 8'h5A;
         xfer(2);
         shadow[i] = 8'(i) ^ 8'h5A;
         if (mem[i] != shadow[i] || wr_cnt != w0 + 1) bad++;
         check(mem[i] == shadow[i], "R1 R2 single write data", mem[i], shadow[i]);
      end
      check(bad == 0, "R2 one strobe per write", bad, 0);
      check(wr_cnt == 128, "R2 write count", wr_cnt, 128);

      // R4 single read of every address
      for (int i = 0; i < 128; i++) begin
         tx_b[0] = 8'h80 | 8'(i);
         tx_b[1] = 8'h00;
         xfer(2);
         check(rx_b[1] == shadow[i], "R1 R4 single read", rx_b[1], shadow[i]);
      end

      // R3 write burst crossing 127 -> 0
      w0 = wr_cnt;
      tx_b[0] = 8'd126;
      for (int k = 1; k <= 4; k++) tx_b[k] = 8'hC0 + 8'(k);
      xfer(5);
      for (int k = 0; k < 4; k++) begin
         a = 7'(126 + k);
         shadow[a] = 8'hC1 + 8'(k);
         check(mem[a] == shadow[a], "R3 burst write wrap", mem[a], shadow[a]);
      end
      check(wr_cnt == w0 + 4, "R3 burst strobes", wr_cnt, w0 + 4);

      // R5 read burst crossing 127 -> 0
      tx_b[0] = 8'h80 | 8'd125;
      for (int k = 1; k <= 5; k++) tx_b[k] = 8'h00;
      xfer(6);
      for (int k = 0; k < 5; k++) begin
         a = 7'(125 + k);
         check(rx_b[k+1] == shadow[a], "R5 burst read wrap", rx_b[k+1], shadow[a]);
      end

      // R7 fast mode drops writes
      fast_mode = 1'b1;
      repeat (4) @(negedge clk);
      w0 = wr_cnt;
      tx_b[0] = 8'h21;
      tx_b[1] = 8'hEE; tx_b[2] = 8'hEF; tx_b[3] = 8'hF0;
      xfer(4);
      check(wr_cnt == w0, "R7 no write strobe", wr_cnt, w0);
      for (int k = 0; k < 3; k++)
         check(mem[33+k] == shadow[33+k], "R7 registers unchanged", mem[33+k], shadow[33+k]);

      // R8 window edges, low side
      tx_b[0] = 8'h80 | 8'(LO - 1);
      for (int k = 1; k <= 3; k++) tx_b[k] = 8'h00;
      xfer(4);
      check(rx_b[1] == 8'h00, "R8 below window", rx_b[1], 0);
      check(rx_b[2] == shadow[LO], "R8 first in window", rx_b[2], shadow[LO]);
      check(rx_b[3] == shadow[LO+1], "R8 second in window", rx_b[3], shadow[LO+1]);
      // high side
      tx_b[0] = 8'h80 | 8'(HI);
      xfer(3);
      check(rx_b[1] == shadow[HI], "R8 last in window", rx_b[1], shadow[HI]);
      check(rx_b[2] == 8'h00, "R8 above window", rx_b[2], 0);
      check(rd_bad == 0, "R8 no strobe outside window", rd_bad, 0);
      fast_mode = 1'b0;
      repeat (4) @(negedge clk);

      // R9 abort mid data byte and mid command byte
      w0 = wr_cnt;
      partial({8'h40, 8'hA5}, 12);
      check(wr_cnt == w0, "R9 aborted write dropped", wr_cnt, w0);
      check(mem[64] == shadow[64], "R9 register kept", mem[64], shadow[64]);
      partial(16'hFFFF, 5);
      tx_b[0] = 8'h80 | 8'h55;
      tx_b[1] = 8'h00;
      xfer(2);
      check(rx_b[1] == shadow[8'h55], "R9 fresh command after abort", rx_b[1], shadow[8'h55]);
      check(wr_cnt == w0, "R9 no stray write", wr_cnt, w0);

      summary();
      $finish;
   end

endmodule